// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit processor that runs a small integer instruction subset. It takes the 6-bit opcode and the 6-bit function field of the current instruction. From them it produces the steering and enable signals for the datapath: destination register selection, register write enable, immediate extension mode, second ALU operand selection, data memory read and write enables, the load write-back select, the three flow-control flags and a 4-bit ALU operation code.

Decoding is split into two levels. The opcode stage sets every datapath control and an internal ALU operation class. The ALU stage then resolves that class, using the function field only when the class says the instruction is register-to-register. For those instructions the 4-bit ALU code is simply the low nibble of the function field. Every other instruction maps onto the same code as its register-to-register counterpart. An opcode outside the supported set yields an inert output that writes nothing and does not redirect the program counter.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcodes decoded: register type 0x00, jump 0x02, branch-equal 0x04, branch-not-equal 0x05, add-immediate 0x08, set-less-than-immediate 0x0A, and-immediate 0x0C, or-immediate 0x0D, xor-immediate 0x0E, load word 0x23, store word 0x2B. `reg_dst` is 1 only for opcode 0x00.
- R2: `reg_wr` is 0 for store, both branches and jump, and 1 for every other supported opcode.
- R3: `imm_sign` is 0 (zero extension) for and-, or- and xor-immediate, and 1 (sign extension) for every other opcode.
- R4: `alu_src` is 0 (register operand) for opcode 0x00, both branches and unsupported opcodes, and 1 (immediate) for the rest.
- R5: `mem_rd` and `mem_to_reg` are 1 only for load word; `mem_wr` is 1 only for store word.
- R6: ALU codes: for opcode 0x00 `alu_ctl` equals `funct[3:0]` (add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, slt 0x2A, giving 0000, 0010, 0100, 0101, 0110, 1010); load, store, add-immediate and jump give 0000, the branches give 0010, and/or/xor-immediate give 0100/0101/0110, set-less-than-immediate gives 1010.
- R7: `jump` is 1 only for 0x02, `br_eq` only for 0x04, `br_ne` only for 0x05; at most one of the three is ever 1.
- R8: An unsupported opcode drives `reg_wr`, `mem_rd`, `mem_wr`, `mem_to_reg`, `br_eq`, `br_ne`, `jump` and `reg_dst` to 0, `imm_sign` to 1 and `alu_ctl` to 0000.
- R9: When the opcode is not 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| reg_dst | output | 1 | 1 selects the Rd field as write register, 0 selects Rt |
| reg_wr | output | 1 | Register file write enable |
| imm_sign | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_src | output | 1 | 1 selects the extended immediate as second ALU operand |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1 writes memory data back instead of the ALU result |
| br_eq | output | 1 | Branch taken when operands are equal |
| br_ne | output | 1 | Branch taken when operands differ |
| jump | output | 1 | Unconditional jump |
| alu_ctl | output | 4 | ALU operation code |

## Verification
The bench sweeps every supported instruction and compares the complete output word, so a swapped opcode or a wrong extension mode on one logical immediate shows as a mismatch on that row alone. It then feeds an immediate instruction with a function field that looks like set-less-than: a decoder that always consults the function field would emit 1010 instead of the immediate's own code. An unsupported opcode is applied to catch a default that leaves a write or branch enable high, which would corrupt state on stray code. A register-type instruction with an unlisted function value confirms that the low nibble passes straight through rather than being forced to add.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       reg_dst,
  output logic       reg_wr,
  output logic       imm_sign,
  output logic       alu_src,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_to_reg,
  output logic       br_eq,
  output logic       br_ne,
  output logic       jump,
  output logic [3:0] alu_ctl
);

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [3:0] ALU_ADD = 4'b0000;
  localparam logic [3:0] ALU_SUB = 4'b0010;
  localparam logic [3:0] ALU_AND = 4'b0100;
  localparam logic [3:0] ALU_OR  = 4'b0101;
  localparam logic [3:0] ALU_XOR = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b1010;

  typedef enum logic [2:0] {
    CLS_ADD, CLS_SUB, CLS_FUNCT, CLS_AND, CLS_OR, CLS_XOR, CLS_SLT
  } alu_cls_e;

  alu_cls_e alu_cls;

  always_comb begin
    reg_dst    = 1'b0;
    reg_wr     = 1'b0;
    imm_sign   = 1'b1;
    alu_src    = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    mem_to_reg = 1'b0;
    br_eq      = 1'b0;
    br_ne      = 1'b0;
    jump       = 1'b0;
    alu_cls    = CLS_ADD;
    case (opcode)
      OP_REG: begin
        reg_dst = 1'b1;
        reg_wr  = 1'b1;
        alu_cls = CLS_FUNCT;
      end
      OP_JMP: begin
        alu_src = 1'b1;
        jump    = 1'b1;
      end
      OP_BEQ: begin
        br_eq   = 1'b1;
        alu_cls = CLS_SUB;
      end
      OP_BNE: begin
        br_ne   = 1'b1;
        alu_cls = CLS_SUB;
      end
      OP_ADDI: begin
        reg_wr  = 1'b1;
        alu_src = 1'b1;
      end
      OP_SLTI: begin
        reg_wr  = 1'b1;
        alu_src = 1'b1;
        alu_cls = CLS_SLT;
      end
      OP_ANDI: begin
        reg_wr   = 1'b1;
        alu_src  = 1'b1;
        imm_sign = 1'b0;
        alu_cls  = CLS_AND;
      end
      OP_ORI: begin
        reg_wr   = 1'b1;
        alu_src  = 1'b1;
        imm_sign = 1'b0;
        alu_cls  = CLS_OR;
      end
      OP_XORI: begin
        reg_wr   = 1'b1;
        alu_src  = 1'b1;
        imm_sign = 1'b0;
        alu_cls  = CLS_XOR;
      end
      OP_LW: begin
        reg_wr     = 1'b1;
        alu_src    = 1'b1;
        mem_rd     = 1'b1;
        mem_to_reg = 1'b1;
      end
      OP_SW: begin
        alu_src = 1'b1;
        mem_wr  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (alu_cls)
      CLS_FUNCT: alu_ctl = funct[3:0];
      CLS_SUB:   alu_ctl = ALU_SUB;
      CLS_AND:   alu_ctl = ALU_AND;
      CLS_OR:    alu_ctl = ALU_OR;
      CLS_XOR:   alu_ctl = ALU_XOR;
      CLS_SLT:   alu_ctl = ALU_SLT;
      default:   alu_ctl = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic       reg_dst,
  input logic       reg_wr,
  input logic       imm_sign,
  input logic       alu_src,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mem_to_reg,
  input logic       br_eq,
  input logic       br_ne,
  input logic       jump,
  input logic [3:0] alu_ctl
);

  always_comb begin
    AST_ONE_FLOW: assert ($onehot0({br_eq, br_ne, jump}));                            // R7
    AST_STORE_NO_WRITE: assert (!mem_wr || (!reg_wr && !mem_rd));                     // R5
    AST_LOAD_PAIR: assert (mem_rd == mem_to_reg);                                      // R5
    AST_MEM_ADDS: assert (!(mem_rd || mem_wr) || (alu_src && alu_ctl == 4'b0000));     // R6
    AST_BRANCH_SUB: assert (!(br_eq || br_ne) || (!alu_src && !reg_wr && alu_ctl == 4'b0010)); // R4
    AST_RDST_REG: assert (!reg_dst || (reg_wr && !alu_src));                           // R1
    AST_ZEXT_IMM: assert (imm_sign || (alu_src && reg_wr));                            // R3
  end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
  .reg_dst(reg_dst), .reg_wr(reg_wr), .imm_sign(imm_sign), .alu_src(alu_src),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
  .br_eq(br_eq), .br_ne(br_ne), .jump(jump), .alu_ctl(alu_ctl)
);

// File: tb/ctrl_decoder_tb.sv
module ctrl_decoder_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h3F;
  logic [5:0] funct  = 6'h00;
  logic reg_dst, reg_wr, imm_sign, alu_src, mem_rd, mem_wr, mem_to_reg;
  logic br_eq, br_ne, jump;
  logic [3:0] alu_ctl;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctrl_decoder u_dut (
    .opcode(opcode), .funct(funct), .reg_dst(reg_dst), .reg_wr(reg_wr),
    .imm_sign(imm_sign), .alu_src(alu_src), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_to_reg(mem_to_reg), .br_eq(br_eq), .br_ne(br_ne), .jump(jump),
    .alu_ctl(alu_ctl)
  );

  // {opcode, funct, reg_dst, reg_wr, imm_sign, alu_src, mem_rd, mem_wr, mem_to_reg, br_eq, br_ne, jump, alu_ctl}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {6'h00, 6'h20, 10'b1110000000, 4'b0000},
    {6'h00, 6'h22, 10'b1110000000, 4'b0010},
    {6'h00, 6'h24, 10'b1110000000, 4'b0100},
    {6'h00, 6'h25, 10'b1110000000, 4'b0101},
    {6'h00, 6'h26, 10'b1110000000, 4'b0110},
    {6'h00, 6'h2A, 10'b1110000000, 4'b1010},
    {6'h08, 6'h00, 10'b0111000000, 4'b0000},
    {6'h0A, 6'h00, 10'b0111000000, 4'b1010},
    {6'h0C, 6'h00, 10'b0101000000, 4'b0100},
    {6'h0D, 6'h00, 10'b0101000000, 4'b0101},
    {6'h0E, 6'h00, 10'b0101000000, 4'b0110},
    {6'h23, 6'h00, 10'b0111101000, 4'b0000},
    {6'h2B, 6'h00, 10'b0011010000, 4'b0000},
    {6'h04, 6'h00, 10'b0010000100, 4'b0010},
    {6'h05, 6'h00, 10'b0010000010, 4'b0010},
    {6'h02, 6'h00, 10'b0011000001, 4'b0000},
    {6'h3F, 6'h00, 10'b0010000000, 4'b0000}
  };

  function automatic logic [13:0] outs();
    return {reg_dst, reg_wr, imm_sign, alu_src, mem_rd, mem_wr, mem_to_reg,
            br_eq, br_ne, jump, alu_ctl};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                       input logic [13:0] exp, input string tag);
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s op=%h funct=%h actual=%b expected=%b", tag, op, fn, outs(), exp);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outs() !== 14'b0010000000_0000) begin
      errors++;
      $display("FAIL R8 idle state actual=%b expected=%b", outs(), 14'b0010000000_0000);
    end
    for (int i = 0; i < NV; i++)
      apply(VEC[i][25:20], VEC[i][19:14], VEC[i][13:0], "R1 R2 R3 R4 R5 R6 R7 table");
    apply(6'h08, 6'h2A, 14'b0111000000_0000, "R9 addi with slt funct");
    apply(6'h0C, 6'h3F, 14'b0101000000_0100, "R9 andi with ones funct");
    apply(6'h23, 6'h22, 14'b0111101000_0000, "R9 lw with sub funct");
    apply(6'h00, 6'h27, 14'b1110000000_0111, "R6 unlisted funct passes low nibble");
    apply(6'h01, 6'h20, 14'b0010000000_0000, "R8 unsupported opcode 0x01");
    apply(6'h2A, 6'h00, 14'b0010000000_0000, "R8 unsupported opcode 0x2A");
    apply(6'h03, 6'h00, 14'b0010000000_0000, "R7 neighbour of jump opcode");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule